// File: doc/BRIEF.md
# JTAG-Driven Power Mode Controller

This block lets a test access port steer a device's low-power freeze and its authentication circuit without touching the board's freeze pin. Each time the instruction register is updated, the block reads the new 8-bit opcode. A few dedicated opcodes select one of four modes: pin control, active, forced freeze and authenticate. All other opcodes leave the mode as it is, except in authenticate, where they end that mode.

The block runs entirely on the JTAG test clock, because the core clocks stop during freeze. It produces two outputs. The first is an active-high low-power request, which the analog low-power cell combines with the active-low external freeze pin. The second is an enable for the authentication circuit. Authenticate is entered from any other mode, and the block remembers that mode. While authenticate is held, the encryption-init, descramble, verify and bypass opcodes keep it there. Any other opcode restores the remembered mode.

Top module: `jtag_pwr_ctrl`

## Requirements
- R1: While rst_ni is low, and afterwards until a mode-changing opcode is decoded, the block is in pin control: auth_en_o is 0 and lp_req_o equals the inverse of frz_pin_ni.
- R2: Outside authenticate, opcode 0x7E decoded on an update strobe selects forced freeze, in which lp_req_o is 1 whatever the level of frz_pin_ni.
- R3: Outside authenticate, opcode 0x7F selects active, in which lp_req_o and auth_en_o are both 0.
- R4: Outside authenticate, opcode 0x7D selects pin control, in which lp_req_o follows the inverse of frz_pin_ni combinationally.
- R5: Opcode 0xDD selects authenticate from any mode, in which auth_en_o is 1 and lp_req_o is 0. auth_en_o is 1 in no other mode.
- R6: In authenticate, opcodes 0x0A, 0xDF, 0xFF and 0xDD keep the block in authenticate.
- R7: In authenticate, any other opcode, including 0x7E, 0x7F and 0x7D, restores the mode that was in force when authenticate was entered.
- R8: Outside authenticate, an opcode other than 0x7E, 0x7F, 0x7D and 0xDD leaves the mode unchanged.
- R9: When ir_upd_i is low at a rising tck_i edge, ir_i has no effect on the mode.
- R10: Forced freeze is left only through 0x7F, 0x7D or a round trip through authenticate. Bypass and other opcodes keep lp_req_o at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck_i | input | 1 | JTAG test clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | IR_W (8) | Instruction register value, presented in parallel |
| ir_upd_i | input | 1 | One-cycle strobe marking that a new instruction has been latched |
| frz_pin_ni | input | 1 | External freeze pin, active low |
| lp_req_o | output | 1 | Low-power request, active high |
| auth_en_o | output | 1 | Authentication circuit enable |

## Verification
The assertions assume that ir_i is meaningful only in a cycle where ir_upd_i is high, and that ir_upd_i is a single-cycle pulse for each new instruction. They also assume that frz_pin_ni may change at any time, so every check that involves it compares against the pin's current level. The stimulus changes inputs only at falling tck_i edges and raises the strobe for one cycle per vector. It drives the pin to the level that tells the modes apart: low separates pin control from active, and high separates forced freeze from pin control.

// File: rtl/jpc_pkg.sv
package jpc_pkg;
  typedef enum logic [1:0] {
    MODE_PIN  = 2'd0,
    MODE_ACT  = 2'd1,
    MODE_FRZ  = 2'd2,
    MODE_AUTH = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_FRZ  = 3'd1,
    CMD_ACT  = 3'd2,
    CMD_PIN  = 3'd3,
    CMD_AUTH = 3'd4,
    CMD_HOLD = 3'd5
  } cmd_e;
endpackage

// File: rtl/jpc_decode.sv
module jpc_decode
  import jpc_pkg::*;
#(
  parameter int                     IR_W     = 8,
  parameter int                     HOLD_N   = 3,
  parameter logic [IR_W-1:0]        OPC_FRZ  = 8'h7E,
  parameter logic [IR_W-1:0]        OPC_ACT  = 8'h7F,
  parameter logic [IR_W-1:0]        OPC_PIN  = 8'h7D,
  parameter logic [IR_W-1:0]        OPC_AUTH = 8'hDD,
  parameter logic [HOLD_N*IR_W-1:0] OPC_HOLD = {8'h0A, 8'hDF, 8'hFF}
) (
  input  logic [IR_W-1:0] ir_i,
  output cmd_e            cmd_o
);
  logic [HOLD_N-1:0] hold_hit;

  for (genvar g = 0; g < HOLD_N; g++) begin : g_hold
    assign hold_hit[g] = (ir_i == OPC_HOLD[g*IR_W +: IR_W]);
  end

  always_comb begin
    if      (ir_i == OPC_FRZ)  cmd_o = CMD_FRZ;
    else if (ir_i == OPC_ACT)  cmd_o = CMD_ACT;
    else if (ir_i == OPC_PIN)  cmd_o = CMD_PIN;
    else if (ir_i == OPC_AUTH) cmd_o = CMD_AUTH;
    else if (|hold_hit)        cmd_o = CMD_HOLD;
    else                       cmd_o = CMD_NONE;
  end
endmodule

// File: rtl/jpc_mode_fsm.sv
module jpc_mode_fsm
  import jpc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  upd_i,
  input  cmd_e  cmd_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;
  mode_e saved_q;
  logic  enter_auth;

  assign enter_auth = upd_i && (mode_q != MODE_AUTH) && (cmd_i == CMD_AUTH);

  always_comb begin
    mode_d = mode_q;
    if (upd_i) begin
      if (mode_q == MODE_AUTH) begin
        // only the hold set and a repeated init keep authenticate
        if (!(cmd_i inside {CMD_AUTH, CMD_HOLD})) mode_d = saved_q;
      end else begin
        unique case (cmd_i)
          CMD_FRZ:  mode_d = MODE_FRZ;
          CMD_ACT:  mode_d = MODE_ACT;
          CMD_PIN:  mode_d = MODE_PIN;
          CMD_AUTH: mode_d = MODE_AUTH;
          default:  mode_d = mode_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_PIN;
    else         mode_q <= mode_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         saved_q <= MODE_PIN;
    else if (enter_auth) saved_q <= mode_q;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/jpc_out.sv
module jpc_out
  import jpc_pkg::*;
(
  input  mode_e mode_i,
  input  logic  frz_pin_ni,
  output logic  lp_req_o,
  output logic  auth_en_o
);
  always_comb begin
    unique case (mode_i)
      MODE_PIN:  lp_req_o = ~frz_pin_ni;
      MODE_FRZ:  lp_req_o = 1'b1;
      default:   lp_req_o = 1'b0;
    endcase
  end

  assign auth_en_o = (mode_i == MODE_AUTH);
endmodule

// File: rtl/jtag_pwr_ctrl.sv
module jtag_pwr_ctrl
  import jpc_pkg::*;
#(
  parameter int                     IR_W     = 8,
  parameter int                     HOLD_N   = 3,
  parameter logic [IR_W-1:0]        OPC_FRZ  = 8'h7E,
  parameter logic [IR_W-1:0]        OPC_ACT  = 8'h7F,
  parameter logic [IR_W-1:0]        OPC_PIN  = 8'h7D,
  parameter logic [IR_W-1:0]        OPC_AUTH = 8'hDD,
  parameter logic [HOLD_N*IR_W-1:0] OPC_HOLD = {8'h0A, 8'hDF, 8'hFF}
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic [IR_W-1:0] ir_i,
  input  logic            ir_upd_i,
  input  logic            frz_pin_ni,
  output logic            lp_req_o,
  output logic            auth_en_o
);
  cmd_e  cmd;
  mode_e mode;

  jpc_decode #(
    .IR_W(IR_W), .HOLD_N(HOLD_N), .OPC_FRZ(OPC_FRZ), .OPC_ACT(OPC_ACT),
    .OPC_PIN(OPC_PIN), .OPC_AUTH(OPC_AUTH), .OPC_HOLD(OPC_HOLD)
  ) u_dec (
    .ir_i (ir_i),
    .cmd_o(cmd)
  );

  jpc_mode_fsm u_fsm (
    .clk_i (tck_i),
    .rst_ni(rst_ni),
    .upd_i (ir_upd_i),
    .cmd_i (cmd),
    .mode_o(mode)
  );

  jpc_out u_out (
    .mode_i    (mode),
    .frz_pin_ni(frz_pin_ni),
    .lp_req_o  (lp_req_o),
    .auth_en_o (auth_en_o)
  );
endmodule

// File: rtl/jtag_pwr_ctrl_chk.sv
module jtag_pwr_ctrl_chk #(
  parameter int                     IR_W     = 8,
  parameter int                     HOLD_N   = 3,
  parameter logic [IR_W-1:0]        OPC_FRZ  = 8'h7E,
  parameter logic [IR_W-1:0]        OPC_ACT  = 8'h7F,
  parameter logic [IR_W-1:0]        OPC_PIN  = 8'h7D,
  parameter logic [IR_W-1:0]        OPC_AUTH = 8'hDD,
  parameter logic [HOLD_N*IR_W-1:0] OPC_HOLD = {8'h0A, 8'hDF, 8'hFF}
) (
  input logic            tck_i,
  input logic            rst_ni,
  input logic [IR_W-1:0] ir_i,
  input logic            ir_upd_i,
  input logic            frz_pin_ni,
  input logic            lp_req_o,
  input logic            auth_en_o
);
  logic keep;
  always_comb begin
    keep = (ir_i == OPC_AUTH);
    for (int k = 0; k < HOLD_N; k++)
      if (ir_i == OPC_HOLD[k*IR_W +: IR_W]) keep = 1'b1;
  end

  // R1
  rst_state_chk: assert property (@(posedge tck_i)
    !rst_ni |-> (!auth_en_o && (lp_req_o == !frz_pin_ni)));

  // R2
  freeze_sel_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_upd_i && ir_i == OPC_FRZ && !auth_en_o) |=> lp_req_o);

  // R3
  active_sel_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_upd_i && ir_i == OPC_ACT && !auth_en_o) |=> (!lp_req_o && !auth_en_o));

  // R4
  pin_sel_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_upd_i && ir_i == OPC_PIN && !auth_en_o) |=> (lp_req_o == !frz_pin_ni));

  // R5
  auth_enter_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ir_upd_i && ir_i == OPC_AUTH) |=> auth_en_o);

  // R5
  auth_awake_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    auth_en_o |-> !lp_req_o);

  // R6
  auth_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (auth_en_o && ir_upd_i && keep) |=> auth_en_o);

  // R7
  auth_exit_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (auth_en_o && ir_upd_i && !keep) |=> !auth_en_o);

  // R9
  no_strobe_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !ir_upd_i |=> $stable(auth_en_o));
endmodule

bind jtag_pwr_ctrl jtag_pwr_ctrl_chk #(
  .IR_W(IR_W), .HOLD_N(HOLD_N), .OPC_FRZ(OPC_FRZ), .OPC_ACT(OPC_ACT),
  .OPC_PIN(OPC_PIN), .OPC_AUTH(OPC_AUTH), .OPC_HOLD(OPC_HOLD)
) u_chk (.*);

// File: tb/sim_jtag_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_jtag_pwr_ctrl;
  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ir = 8'h00;
  logic       upd = 1'b0;
  logic       pin_n = 1'b1;
  logic       lp_req, auth_en;
  int         checks = 0;
  int         fails  = 0;
  int         cycles = 0;
  bit         done   = 1'b0;

  always #2 tck = ~tck;

  jtag_pwr_ctrl u0 (
    .tck_i(tck), .rst_ni(rst_n), .ir_i(ir), .ir_upd_i(upd),
    .frz_pin_ni(pin_n), .lp_req_o(lp_req), .auth_en_o(auth_en)
  );

  // vector: {upd, ir[7:0], pin_n, exp_lp, exp_auth, req[3:0]}
  localparam int NV = 22;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 4'd1},   // R1 pin ctl, pin asserted
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd1},   // R1 pin ctl, pin released
    {1'b1, 8'h7F, 1'b0, 1'b0, 1'b0, 4'd3},   // R3 active
    {1'b1, 8'h42, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 unknown opcode
    {1'b1, 8'h7E, 1'b1, 1'b1, 1'b0, 4'd2},   // R2 forced freeze
    {1'b1, 8'h0A, 1'b1, 1'b1, 1'b0, 4'd10},  // R10
    {1'b1, 8'hFF, 1'b1, 1'b1, 1'b0, 4'd10},  // R10 bypass
    {1'b0, 8'h7F, 1'b1, 1'b1, 1'b0, 4'd9},   // R9 no strobe
    {1'b1, 8'hDD, 1'b1, 1'b0, 1'b1, 4'd5},   // R5 enter auth from freeze
    {1'b1, 8'h0A, 1'b1, 1'b0, 1'b1, 4'd6},   // R6
    {1'b1, 8'hDF, 1'b1, 1'b0, 1'b1, 4'd6},   // R6
    {1'b1, 8'hFF, 1'b1, 1'b0, 1'b1, 4'd6},   // R6
    {1'b1, 8'hDD, 1'b1, 1'b0, 1'b1, 4'd6},   // R6 repeated init
    {1'b1, 8'h7F, 1'b1, 1'b1, 1'b0, 4'd7},   // R7 7F restores freeze
    {1'b1, 8'h7F, 1'b1, 1'b0, 1'b0, 4'd3},   // R3
    {1'b1, 8'hDD, 1'b0, 1'b0, 1'b1, 4'd5},   // R5 from active
    {1'b1, 8'h13, 1'b0, 1'b0, 1'b0, 4'd7},   // R7 back to active
    {1'b1, 8'h7D, 1'b0, 1'b1, 1'b0, 4'd4},   // R4 pin ctl
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 4'd4},   // R4 follows pin
    {1'b1, 8'hDD, 1'b0, 1'b0, 1'b1, 4'd5},   // R5 from pin ctl
    {1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 4'd7},   // R7 7E restores pin ctl
    {1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 4'd8}    // R8
  };

  task automatic chk(input logic exp_lp, input logic exp_au, input int req);
    checks++;
    if (lp_req !== exp_lp || auth_en !== exp_au) begin
      fails++;
      $display("FAIL R%0d: lp_req=%b auth_en=%b expected lp_req=%b auth_en=%b",
               req, lp_req, auth_en, exp_lp, exp_au);
    end
  endtask

  task automatic step(input logic u, input logic [7:0] op, input logic p);
    @(negedge tck);
    upd = u; ir = op; pin_n = p;
    @(posedge tck);
    #1;
  endtask

  initial begin
    // R1 reset state
    pin_n = 1'b0; #1; chk(1'b1, 1'b0, 1);
    pin_n = 1'b1; #1; chk(1'b0, 1'b0, 1);
    repeat (3) @(negedge tck);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15], VEC[i][14:7], VEC[i][6]);
      chk(VEC[i][5], VEC[i][4], int'(VEC[i][3:0]));
    end

    // R9 stream of opcodes without strobe while active
    step(1'b1, 8'h7F, 1'b0);
    for (int k = 0; k < 4; k++) begin
      step(1'b0, (k % 2 == 0) ? 8'h7E : 8'hDD, 1'b0);
      chk(1'b0, 1'b0, 9);
    end

    // R1 asynchronous reset from forced freeze
    step(1'b1, 8'h7E, 1'b1);
    chk(1'b1, 1'b0, 2);
    @(negedge tck); upd = 1'b0;
    #0.5 rst_n = 1'b0; #0.5;
    chk(1'b0, 1'b0, 1);
    @(negedge tck); rst_n = 1'b1;

    // R1 reset from authenticate
    step(1'b1, 8'hDD, 1'b0);
    chk(1'b0, 1'b1, 5);
    @(negedge tck); upd = 1'b0; rst_n = 1'b0; #0.5;
    chk(1'b1, 1'b0, 1);
    @(negedge tck); rst_n = 1'b1;

    // R7 saved mode is pin ctl after reset: auth then bypass exit with unknown
    step(1'b1, 8'hDD, 1'b0);
    step(1'b1, 8'h55, 1'b0);
    chk(1'b1, 1'b0, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge tck) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule